// File: doc/BRIEF.md
# Latency-insensitive relay station

The relay station is a single pipeline stage that is inserted on a long point-to-point channel between two wrapped synchronous blocks. Forward, it carries a data word together with a valid flag, one cycle behind its input. Backward, it carries a stop flag. A token whose valid flag is low is void: it holds no information, and its data word is don't-care. After reset the stage presents a void token, so a freshly started channel delivers voids first.

The stage has a main register, which drives the output, and an auxiliary register. When the downstream block raises stop while the stage shows a valid token, the stage keeps that token on its output and raises its own upstream stop one cycle later. A token that the upstream side hands over in that one-cycle gap goes into the auxiliary register, so nothing is overrun. When stop is released, the main token leaves first and the auxiliary token follows it. A stop that meets a void token is absorbed: the void is simply held, and nothing is sent upstream. An upstream token counts as handed over only in a cycle where the stage's upstream stop is low. While that stop is high, the upstream block keeps its token and offers it again later.

A four-state controller runs the stage:
- VOID: main register empty, upstream stop low.
- FLOW: main register full, auxiliary register empty, upstream stop low.
- STALL: main register full, auxiliary register empty, upstream stop high.
- FULL: both registers full, upstream stop high.

Its transitions, with "accept" meaning in_valid high and out_stop low, and "release" meaning in_stop low:
- VOID to FLOW on accept. Otherwise VOID stays in VOID, with or without stop.
- FLOW to FLOW on accept with release. FLOW to VOID on release with no accept.
- FLOW to FULL on accept with stop, which loads the auxiliary register. FLOW to STALL on stop with no accept.
- STALL to VOID on release. STALL stays in STALL under stop.
- FULL to FLOW on release, which moves the auxiliary token into the main register. FULL stays in FULL under stop.

Top module: `relay_station`

## Requirements
- R1: During and right after reset, out_valid and out_stop are both low.
- R2: A token accepted at a clock edge, while the stage is empty or its output token is leaving (in_stop low), appears on out_data with out_valid high right after that edge. This is one cycle of latency.
- R3: With in_stop held low and a valid token offered every cycle, the stage delivers one valid token per cycle, in the order the tokens were offered.
- R4: While out_valid and in_stop are both high, out_valid and out_data are unchanged in the next cycle.
- R5: When in_stop is high while the stage shows a valid token and out_stop is low, out_stop is high in the next cycle.
- R6: When out_valid is low and out_stop is low, out_stop stays low in the next cycle, whatever in_stop is. A stop that meets a void token is absorbed.
- R7: A token accepted in the cycle in which stop first reaches the stage is kept and delivered later. Under any pattern of in_valid and in_stop, the sequence of delivered valid tokens equals the sequence of accepted tokens, with none lost, duplicated or reordered.
- R8: A token offered with in_valid high while out_stop is high is not taken, and it never reaches the output.
- R9: After stop is released in state FULL, the held main token leaves first, and the auxiliary token is on the output in the next cycle. out_stop is low in that same next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | DATA_W | Data word from upstream |
| in_valid | input | 1 | Upstream token is valid |
| out_stop | output | 1 | Back-pressure to upstream |
| out_data | output | DATA_W | Data word to downstream, don't-care when out_valid is low |
| out_valid | output | 1 | Downstream token is valid |
| in_stop | input | 1 | Back-pressure from downstream |

## Verification
The bench builds the stage with DATA_W of 10 and with data-register reset enabled. A 10-bit word lets a running sequence number serve as the token identity, so order, loss and duplication show up directly. Directed steps drive each controller state and transition, including a stop that lands on a void token and a stop that arrives in the same cycle as a new token. These steps also place a marker word on the input while upstream stop is high, to show that it is never taken. A long random phase then mixes stop and valid patterns and compares every delivered word against a scoreboard of accepted words.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        RS_VOID  = 2'd0,
        RS_FLOW  = 2'd1,
        RS_STALL = 2'd2,
        RS_FULL  = 2'd3
    } rs_state_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
    import rs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_valid,
    input  logic      dn_stop,
    output rs_state_t state,
    output logic      main_full,
    output logic      stop_up,
    output logic      ld_main_in,
    output logic      ld_main_aux,
    output logic      ld_aux
);
    rs_state_t state_q, state_d;
    logic      accept, release_dn;

    assign state = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_VOID;
        else        state_q <= state_d;
    end

    // outputs decoded from the current state
    always_comb begin
        main_full = 1'b0;
        stop_up   = 1'b0;
        unique case (state_q)
            RS_VOID:  begin main_full = 1'b0; stop_up = 1'b0; end
            RS_FLOW:  begin main_full = 1'b1; stop_up = 1'b0; end
            RS_STALL: begin main_full = 1'b1; stop_up = 1'b1; end
            RS_FULL:  begin main_full = 1'b1; stop_up = 1'b1; end
            default:  begin main_full = 1'b0; stop_up = 1'b0; end
        endcase
    end

    assign accept     = up_valid & ~stop_up;
    assign release_dn = ~dn_stop;

    // transitions and register load enables
    always_comb begin
        state_d     = state_q;
        ld_main_in  = 1'b0;
        ld_main_aux = 1'b0;
        ld_aux      = 1'b0;
        unique case (state_q)
            RS_VOID: begin
                if (accept) begin
                    state_d    = RS_FLOW;
                    ld_main_in = 1'b1;
                end
            end
            RS_FLOW: begin
                if (release_dn) begin
                    if (accept) begin
                        state_d    = RS_FLOW;
                        ld_main_in = 1'b1;
                    end else begin
                        state_d = RS_VOID;
                    end
                end else if (accept) begin
                    state_d = RS_FULL;
                    ld_aux  = 1'b1;
                end else begin
                    state_d = RS_STALL;
                end
            end
            RS_STALL: begin
                if (release_dn) state_d = RS_VOID;
            end
            RS_FULL: begin
                if (release_dn) begin
                    state_d     = RS_FLOW;
                    ld_main_aux = 1'b1;
                end
            end
            default: state_d = RS_VOID;
        endcase
    end

    // R9: leaving FULL always lands in FLOW with the auxiliary token promoted
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_FULL && !dn_stop) |=> (state_q == RS_FLOW && !stop_up));

    // R7: auxiliary register is only written in the one-cycle stop window
    assert_aux_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_aux |-> (state_q == RS_FLOW && dn_stop && up_valid));
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath #(
    parameter int DATA_W     = 16,
    parameter bit RESET_DATA = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_word,
    input  logic              ld_main_in,
    input  logic              ld_main_aux,
    input  logic              ld_aux,
    output logic [DATA_W-1:0] main_word
);
    localparam logic [DATA_W-1:0] ZERO_W = '0;

    logic [DATA_W-1:0] main_q, aux_q;

    assign main_word = main_q;

    generate
        if (RESET_DATA) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    main_q <= ZERO_W;
                    aux_q  <= ZERO_W;
                end else begin
                    if (ld_main_in)       main_q <= in_word;
                    else if (ld_main_aux) main_q <= aux_q;
                    if (ld_aux)           aux_q  <= in_word;
                end
            end
        end else begin : g_norst
            always_ff @(posedge clk) begin
                if (ld_main_in)       main_q <= in_word;
                else if (ld_main_aux) main_q <= aux_q;
                if (ld_aux)           aux_q  <= in_word;
            end
        end
    endgenerate
endmodule

// File: rtl/relay_station.sv
module relay_station
    import rs_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter bit RESET_DATA = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              out_stop,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              in_stop
);
    rs_state_t st;
    logic      main_full, stop_up, ld_main_in, ld_main_aux, ld_aux;

    rs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_valid    (in_valid),
        .dn_stop     (in_stop),
        .state       (st),
        .main_full   (main_full),
        .stop_up     (stop_up),
        .ld_main_in  (ld_main_in),
        .ld_main_aux (ld_main_aux),
        .ld_aux      (ld_aux)
    );

    rs_datapath #(.DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_word     (in_data),
        .ld_main_in  (ld_main_in),
        .ld_main_aux (ld_main_aux),
        .ld_aux      (ld_aux),
        .main_word   (out_data)
    );

    assign out_valid = main_full;
    assign out_stop  = stop_up;

    // R2: an accepted token that goes straight to the main register shows next cycle
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_stop && (!out_valid || !in_stop))
        |=> (out_valid && out_data == $past(in_data)));

    // R4: a stopped valid token is held
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_stop) |=> (out_valid && $stable(out_data)));

    // R5: stop on a valid token is forwarded one cycle later
    assert_stop_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_stop && !out_stop) |=> out_stop);

    // R6: stop on a void token is absorbed
    assert_void_absorb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !out_stop) |=> !out_stop);
endmodule

// File: tb/relay_station_tb.sv
module relay_station_tb_top;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_stop = 1'b0;
    logic         out_stop, out_valid;
    logic [W-1:0] out_data;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    int  n_sent = 0;
    int  n_recv = 0;
    logic [W-1:0] sb[$];

    always #5 clk = ~clk;

    relay_station #(.DATA_W(W), .RESET_DATA(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .out_stop(out_stop), .out_data(out_data), .out_valid(out_valid),
        .in_stop(in_stop)
    );

    function automatic bit accepted(input logic v, input logic s);
        return v && !s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle of inputs, then update the scoreboard for the coming edge
    task automatic drive(input logic v, input logic [W-1:0] d, input logic s);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        in_stop  = s;
        #1;
        if (accepted(out_valid, in_stop)) begin
            n_recv++;
            if (sb.size() == 0) chk("R7 unexpected token", {22'd0, out_data}, 32'hFFFF);
            else chk("R7 order", {22'd0, out_data}, {22'd0, sb.pop_front()});
        end
        if (accepted(in_valid, out_stop)) begin
            sb.push_back(in_data);
            n_sent++;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] seq;
        logic         have;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1 out_stop in reset", {31'd0, out_stop}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R1 out_stop after reset", {31'd0, out_stop}, 32'd0);

        // R2/R3 directed flow
        drive(1'b1, 10'd10, 1'b0);
        drive(1'b1, 10'd11, 1'b0);
        chk("R2 latency valid", {31'd0, out_valid}, 32'd1);
        chk("R2 latency data", {22'd0, out_data}, 32'd10);
        drive(1'b1, 10'd12, 1'b0);
        chk("R3 next data", {22'd0, out_data}, 32'd11);
        // stop arrives while 12 is shown, 13 offered in the same cycle (R7)
        drive(1'b1, 10'd13, 1'b1);
        chk("R3 data before stop", {22'd0, out_data}, 32'd12);
        chk("R5 stop not yet raised", {31'd0, out_stop}, 32'd0);
        // marker offered while stop is high must not be taken (R8)
        drive(1'b1, 10'd77, 1'b1);
        chk("R5 stop raised", {31'd0, out_stop}, 32'd1);
        chk("R4 held data", {22'd0, out_data}, 32'd12);
        drive(1'b1, 10'd77, 1'b1);
        chk("R4 still held", {22'd0, out_data}, 32'd12);
        chk("R4 still valid", {31'd0, out_valid}, 32'd1);
        // release: 12 leaves, 13 moves up (R9)
        drive(1'b1, 10'd14, 1'b0);
        drive(1'b1, 10'd14, 1'b0);
        chk("R9 aux token shown", {22'd0, out_data}, 32'd13);
        chk("R9 stop dropped", {31'd0, out_stop}, 32'd0);
        drive(1'b0, 10'd0, 1'b0);
        chk("R8 marker never shown", {31'd0, out_data == 10'd77}, 32'd0);
        chk("R8 next is 14", {22'd0, out_data}, 32'd14);
        drive(1'b0, 10'd0, 1'b0);
        chk("R6 void reached", {31'd0, out_valid}, 32'd0);
        // stop on a void token is absorbed (R6)
        drive(1'b0, 10'd0, 1'b1);
        drive(1'b0, 10'd0, 1'b1);
        chk("R6 stop absorbed", {31'd0, out_stop}, 32'd0);
        // STALL path: stop with no new token, then release empties the stage
        drive(1'b1, 10'd20, 1'b0);
        drive(1'b0, 10'd0, 1'b1);
        drive(1'b0, 10'd0, 1'b1);
        chk("R5 stall stop", {31'd0, out_stop}, 32'd1);
        chk("R4 stall data", {22'd0, out_data}, 32'd20);
        drive(1'b0, 10'd0, 1'b0);
        drive(1'b0, 10'd0, 1'b0);
        chk("R7 stall drained", {31'd0, out_valid}, 32'd0);

        // R3: sustained flow, one token per cycle
        for (int i = 0; i < 100; i++) begin
            drive(1'b1, W'(100 + i), 1'b0);
            if (i > 0) chk("R3 one per cycle", {31'd0, out_valid}, 32'd1);
        end

        // R7: random stimulus, upstream holds a token until it is taken
        seq  = '0;
        have = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            logic offer, stp;
            if (!have) begin
                seq  = seq + 1'b1;
                have = 1'b1;
            end
            offer = ($urandom % 4) != 0;
            stp   = ($urandom % 10) < 4;
            drive(have && offer, offer ? seq : W'($urandom), stp);
            if (have && offer && !out_stop) have = 1'b0;
        end
        for (int i = 0; i < 6; i++) drive(1'b0, '0, 1'b0);
        chk("R7 nothing left", sb.size(), 32'd0);
        chk("R7 counts match", n_recv, n_sent);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule